// File: doc/BRIEF.md
# Four-Lane Framed Sample Serializer

This block takes one parallel sample word per conversion period for each of several channels and sends each word out, one bit per cycle of a fast internal clock, on a lane of its own. The internal clock runs at WORD_W times the sample rate, so a whole word leaves in exactly one sample period. The same counter that steps the lanes also produces a frame clock at the sample rate and a bit clock at half the internal rate. A receiver captures the lanes on both edges of the bit clock and uses the rising frame clock to find the first bit of each word.

Two configuration inputs shape the stream. One picks the bit order. The other replaces the live samples with a fixed deskew word, a fixed sync word or a user-supplied custom word, so that a receiver can train its capture phase and word alignment. A per-lane power-down input holds a lane low. Samples go into a shadow register on a strobe. Samples and configuration reach the lanes only at a frame boundary, so no word on the line ever mixes two sources.

Top module: `sample_lane_serializer`

## Requirements
- R1: A frame lasts WORD_W clock cycles (slots 0 to WORD_W-1). With msbFirst=0 and srcSel=00, lane l carries bit k of sampleData[l*WORD_W +: WORD_W] during slot k.
- R2: bitClk changes only on the falling edge of clk. It is 1 from the middle of each even slot to the middle of the next odd slot and 0 otherwise, so each of its edges falls in the middle of a bit.
- R3: frameClk is 1 during slots 0 to WORD_W/2-1 and 0 during the other slots. It rises in the same cycle that the first bit of a word appears on the lanes.
- R4: With msbFirst=1, slot k carries bit WORD_W-1-k of the selected word.
- R5: srcSel=01 selects the deskew word and srcSel=10 the sync word, on every active lane. In LSB-first order the deskew word sends 1,0,1,0,… (word bit k is 1 for even k). The sync word sends WORD_W/2 zeros and then WORD_W/2 ones.
- R6: srcSel=11 sends customWord in LSB-first order: bits 3:0 first, then bits 7:4, then bits 11:8.
- R7: With msbFirst=1, the deskew, sync and custom words are all sent in reverse order.
- R8: sampleData is captured into the shadow register only in a cycle where sampleStrobe is 1. At any other time changes to it have no effect on the lanes.
- R9: Samples, srcSel, msbFirst, customWord and pwrDown are taken up only at a frame boundary. A change made during a frame leaves that frame unchanged and shows in the next one.
- R10: A lane whose pwrDown bit is 1 at a frame boundary stays at 0 for the whole frame. The other lanes are unaffected.
- R11: While every lane is powered down, frameClk and bitClk stay at 0. When any lane is powered up again, frames resume with the same slot timing.
- R12: While rstN is 0, all lanes, frameClk and bitClk are 0. The first frame starts at the first rising clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, WORD_W times the sample rate |
| rstN | input | 1 | Synchronous reset, active low |
| sampleStrobe | input | 1 | Captures sampleData into the shadow register |
| sampleData | input | NUM_LANES*WORD_W | One sample word per lane, lane 0 in the low bits |
| msbFirst | input | 1 | 0: LSB first, 1: MSB first |
| srcSel | input | 2 | 00 live, 01 deskew, 10 sync, 11 custom |
| customWord | input | WORD_W | Custom pattern word |
| pwrDown | input | NUM_LANES | Per-lane power-down, 1 = lane off |
| laneOut | output | NUM_LANES | Serial data, one bit per lane |
| frameClk | output | 1 | Frame clock at the sample rate |
| bitClk | output | 1 | Bit clock, half the internal clock rate, edges mid-bit |

## Verification
The hardest case to reach is a change made in the middle of a frame. The bench has to prove that the word already on the line keeps its old source and order to the last bit, and that the new value shows up exactly one boundary later. To get there, the capture task moves sampleData, pulses the strobe and switches the source at slot 5 of a frame it is reading. It then reads the next frame without a gap. The full stop of the clocks is reached by powering down every lane, and the bench then checks that frames restart on the same slot grid.

// File: rtl/lane_ser_pkg.sv
package lane_ser_pkg;

  typedef enum logic [1:0] {
    SRC_LIVE   = 2'b00,
    SRC_DESKEW = 2'b01,
    SRC_SYNC   = 2'b10,
    SRC_CUSTOM = 2'b11
  } src_sel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic frameLoad;  // last slot: load next word into the shifters
    logic shiftEn;    // any other slot: advance one bit
  } ser_strobe_t;

endpackage

// File: rtl/lane_ser_ctrl.sv
module lane_ser_ctrl
  import lane_ser_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        allDown,
  output ser_strobe_t strobes,
  output logic        frameClk,
  output logic        bitClk
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam int HALF  = WORD_W / 2;
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] HALF_SLOT = CNT_W'(HALF);

  logic [CNT_W-1:0] slotCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                  slotCnt <= LAST_SLOT;
    else if (slotCnt == LAST_SLOT) slotCnt <= '0;
    else                        slotCnt <= slotCnt + 1'b1;
  end

  assign strobes.frameLoad = (slotCnt == LAST_SLOT);
  assign strobes.shiftEn   = (slotCnt != LAST_SLOT);

  assign frameClk = !allDown && (slotCnt < HALF_SLOT);

  // half-cycle later than the data so each edge lands mid-bit
  always_ff @(negedge clk) begin
    if (!rstN) bitClk <= 1'b0;
    else       bitClk <= !allDown && !slotCnt[0];
  end

endmodule

// File: rtl/lane_ser_datapath.sv
module lane_ser_datapath
  import lane_ser_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int WORD_W    = 12
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ser_strobe_t                   strobes,
  input  logic                          sampleStrobe,
  input  logic [NUM_LANES*WORD_W-1:0]   sampleData,
  input  logic                          msbFirst,
  input  logic [1:0]                    srcSel,
  input  logic [WORD_W-1:0]             customWord,
  input  logic [NUM_LANES-1:0]          pwrDown,
  output logic [NUM_LANES-1:0]          laneOut,
  output logic                          allDown
);

  localparam int HALF = WORD_W / 2;

  function automatic logic [WORD_W-1:0] makeDeskew();
    logic [WORD_W-1:0] w;
    for (int k = 0; k < WORD_W; k++) w[k] = ((k % 2) == 0);
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] makeSync();
    logic [WORD_W-1:0] w;
    for (int k = 0; k < WORD_W; k++) w[k] = (k >= HALF);
    return w;
  endfunction

  localparam logic [WORD_W-1:0] DESKEW_WORD = makeDeskew();
  localparam logic [WORD_W-1:0] SYNC_WORD   = makeSync();

  logic [NUM_LANES*WORD_W-1:0] shadow;
  logic [NUM_LANES-1:0]        laneOff;
  logic [WORD_W-1:0]           patWord;
  src_sel_e                    src;

  assign src = src_sel_e'(srcSel);

  always_ff @(posedge clk) begin
    if (!rstN)             shadow <= '0;
    else if (sampleStrobe) shadow <= sampleData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  laneOff <= '1;
    else if (strobes.frameLoad) laneOff <= pwrDown;
  end

  assign allDown = &laneOff;

  always_comb begin
    case (src)
      SRC_DESKEW: patWord = DESKEW_WORD;
      SRC_SYNC:   patWord = SYNC_WORD;
      default:    patWord = customWord;
    endcase
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [WORD_W-1:0] nextWord;
    logic [WORD_W-1:0] orderedWord;
    logic [WORD_W-1:0] shiftReg;

    assign nextWord = pwrDown[l] ? '0 :
                      (src == SRC_LIVE) ? shadow[l*WORD_W +: WORD_W] : patWord;

    always_comb begin
      for (int k = 0; k < WORD_W; k++)
        orderedWord[k] = msbFirst ? nextWord[WORD_W-1-k] : nextWord[k];
    end

    always_ff @(posedge clk) begin
      if (!rstN)                  shiftReg <= '0;
      else if (strobes.frameLoad) shiftReg <= orderedWord;
      else if (strobes.shiftEn)   shiftReg <= {1'b0, shiftReg[WORD_W-1:1]};
    end

    assign laneOut[l] = shiftReg[0];
  end

endmodule

// File: rtl/sample_lane_serializer.sv
module sample_lane_serializer
  import lane_ser_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int WORD_W    = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sampleStrobe,
  input  logic [NUM_LANES*WORD_W-1:0] sampleData,
  input  logic                        msbFirst,
  input  logic [1:0]                  srcSel,
  input  logic [WORD_W-1:0]           customWord,
  input  logic [NUM_LANES-1:0]        pwrDown,
  output logic [NUM_LANES-1:0]        laneOut,
  output logic                        frameClk,
  output logic                        bitClk
);

  ser_strobe_t strobes;
  logic        allDown;

  lane_ser_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .allDown  (allDown),
    .strobes  (strobes),
    .frameClk (frameClk),
    .bitClk   (bitClk)
  );

  lane_ser_datapath #(.NUM_LANES(NUM_LANES), .WORD_W(WORD_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .sampleStrobe (sampleStrobe),
    .sampleData   (sampleData),
    .msbFirst     (msbFirst),
    .srcSel       (srcSel),
    .customWord   (customWord),
    .pwrDown      (pwrDown),
    .laneOut      (laneOut),
    .allDown      (allDown)
  );

endmodule

// File: rtl/lane_ser_checker.sv
module lane_ser_checker #(
  parameter int NUM_LANES = 4,
  parameter int WORD_W    = 12
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 msbFirst,
  input logic [1:0]           srcSel,
  input logic [NUM_LANES-1:0] pwrDown,
  input logic [NUM_LANES-1:0] laneOut,
  input logic                 frameClk,
  input logic                 bitClk
);

  localparam int HALF = WORD_W / 2;

  int highCnt;

  always_ff @(posedge clk) begin
    if (!rstN)         highCnt <= 0;
    else if (frameClk) highCnt <= highCnt + 1;
    else               highCnt <= 0;
  end

  AST_BITCLK_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameClk) |-> bitClk ##1 !bitClk);  // R2

  AST_FRAME_HIGH_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameClk) |-> highCnt == HALF);  // R3

  AST_DESKEW_LEAD: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(frameClk) && $past(srcSel) == 2'b01 && !$past(msbFirst) && !$past(pwrDown[0]))
      |-> laneOut[0] ##1 !laneOut[0]);  // R5

  AST_ALL_DOWN_NO_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameClk) |-> !(&$past(pwrDown)));  // R11

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_pd
    AST_PD_LANE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(frameClk) && $past(pwrDown[l])) |-> !laneOut[l]);  // R10
  end

endmodule

bind sample_lane_serializer lane_ser_checker #(.NUM_LANES(NUM_LANES), .WORD_W(WORD_W)) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .msbFirst (msbFirst),
  .srcSel   (srcSel),
  .pwrDown  (pwrDown),
  .laneOut  (laneOut),
  .frameClk (frameClk),
  .bitClk   (bitClk)
);

// File: tb/sample_lane_serializer_bench.sv
module sample_lane_serializer_bench;

  localparam int NL   = 4;
  localparam int W    = 12;
  localparam int HALF = W / 2;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            sampleStrobe = 1'b0;
  logic [NL*W-1:0] sampleData = '0;
  logic            msbFirst = 1'b0;
  logic [1:0]      srcSel = 2'b00;
  logic [W-1:0]    customWord = '0;
  logic [NL-1:0]   pwrDown = '0;
  logic [NL-1:0]   laneOut;
  logic            frameClk;
  logic            bitClk;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  logic [W-1:0] got [NL];
  bit fcOk;
  bit bcOk;

  sample_lane_serializer #(.NUM_LANES(NL), .WORD_W(W)) u_sample_lane_serializer (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .sampleData(sampleData),
    .msbFirst(msbFirst), .srcSel(srcSel), .customWord(customWord), .pwrDown(pwrDown),
    .laneOut(laneOut), .frameClk(frameClk), .bitClk(bitClk)
  );

  always #2 clk = ~clk;  // 250 MHz

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // word whose bit k is the bit sent in slot k
  function automatic logic [W-1:0] onLine(logic [W-1:0] w, bit msb);
    logic [W-1:0] r;
    for (int k = 0; k < W; k++) r[k] = msb ? w[W-1-k] : w[k];
    return r;
  endfunction

  function automatic logic [W-1:0] patternWord(int src, logic [W-1:0] live, logic [W-1:0] cw);
    logic [W-1:0] r;
    for (int k = 0; k < W; k++) begin
      case (src)
        0: r[k] = live[k];
        1: r[k] = ((k % 2) == 0);
        2: r[k] = (k >= HALF);
        default: r[k] = cw[k];
      endcase
    end
    return r;
  endfunction

  function automatic logic [NL*W-1:0] makeData(int seed);
    logic [NL*W-1:0] d;
    for (int l = 0; l < NL; l++) d[l*W +: W] = W'((seed * 1237 + l * 291 + 5) & 12'hFFF);
    return d;
  endfunction

  // returns at slot 0 of a frame (1 ns after the edge)
  task automatic waitFrame();
    logic prev;
    prev = frameClk;
    for (int i = 0; i < 4 * W; i++) begin
      @(posedge clk); #1;
      if (frameClk && !prev) return;
      prev = frameClk;
    end
    check(0, "R3", "frame start not seen", 0, 1);
  endtask

  // reads slots 0..W-1; optional change of data/source at slot 5
  task automatic captureFrame(bit mid, logic [NL*W-1:0] midData, logic [1:0] midSrc);
    fcOk = 1; bcOk = 1;
    for (int k = 0; k < W; k++) begin
      if (k > 0) begin @(posedge clk); #1; end
      for (int l = 0; l < NL; l++) got[l][k] = laneOut[l];
      if (frameClk != (k < HALF)) fcOk = 0;
      if (mid && k == 5) begin sampleData = midData; sampleStrobe = 1; srcSel = midSrc; end
      if (mid && k == 6) sampleStrobe = 0;
      #2;
      if (bitClk != ((k % 2) == 0)) bcOk = 0;
    end
  endtask

  task automatic loadSample(logic [NL*W-1:0] d);
    sampleData = d; sampleStrobe = 1;
    @(posedge clk); #1;
    sampleStrobe = 0;
  endtask

  task automatic checkLanes(string req, logic [NL*W-1:0] d, int src, bit msb,
                            logic [W-1:0] cw, logic [NL-1:0] pd);
    for (int l = 0; l < NL; l++) begin
      logic [W-1:0] expW;
      expW = pd[l] ? '0 : onLine(patternWord(src, d[l*W +: W], cw), msb);
      check(got[l] == expW, req, $sformatf("lane %0d src %0d msb %0d", l, src, msb), got[l], expW);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [NL*W-1:0] d0, d1, d2;
    // R12: reset state
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      check(laneOut == '0 && frameClk == 0, "R12", "lanes/frameClk in reset", {laneOut, frameClk}, 0);
      #2;
      check(bitClk == 0, "R12", "bitClk in reset", bitClk, 0);
    end
    rstN = 1;
    @(posedge clk); #1;
    check(frameClk == 1, "R12", "first frame after reset", frameClk, 1);

    // sweep of sources, orders and data
    for (int src = 0; src < 4; src++) begin
      for (int msb = 0; msb < 2; msb++) begin
        for (int seed = 1; seed <= 3; seed++) begin
          string req;
          d0 = makeData(seed * 7 + src);
          customWord = W'(12'hA5C ^ (seed * 273));
          srcSel = 2'(src); msbFirst = msb[0];
          loadSample(d0);
          waitFrame(); waitFrame();
          captureFrame(0, '0, 2'b00);
          if (src == 0) req = msb ? "R4" : "R1";
          else if (msb) req = "R7";
          else req = (src == 3) ? "R6" : "R5";
          checkLanes(req, d0, src, msb[0], customWord, '0);
          check(fcOk, "R3", "frameClk shape", fcOk, 1);
          check(bcOk, "R2", "bitClk phase", bcOk, 1);
        end
      end
    end

    // R6: custom nibble order, fixed value
    customWord = 12'h321; srcSel = 2'b11; msbFirst = 0;
    waitFrame(); waitFrame(); captureFrame(0, '0, 2'b00);
    check(got[1] == 12'h321, "R6", "nibble order 3:0,7:4,11:8", got[1], 12'h321);

    // R9: change data and source mid-frame
    d1 = makeData(101); d2 = makeData(202);
    srcSel = 2'b00; msbFirst = 0;
    loadSample(d1);
    waitFrame(); waitFrame();
    captureFrame(1, d2, 2'b01);
    checkLanes("R9", d1, 0, 0, customWord, '0);
    @(posedge clk); #1;
    // the frame after the change: next loop would skip slot 0, so read it here
    fcOk = 1;
    for (int l = 0; l < NL; l++) got[l][0] = laneOut[l];
    check(frameClk == 1, "R9", "next frame start", frameClk, 1);
    for (int k = 1; k < W; k++) begin
      @(posedge clk); #1;
      for (int l = 0; l < NL; l++) got[l][k] = laneOut[l];
    end
    checkLanes("R9", d2, 1, 0, customWord, '0);

    // R8: data changes without strobe are ignored
    srcSel = 2'b00;
    sampleData = makeData(303);
    waitFrame(); waitFrame(); captureFrame(0, '0, 2'b00);
    checkLanes("R8", d2, 0, 0, customWord, '0);

    // R10: single lane powered down
    pwrDown = 4'b0100;
    loadSample({NL*W{1'b1}});
    waitFrame(); waitFrame(); captureFrame(0, '0, 2'b00);
    checkLanes("R10", {NL*W{1'b1}}, 0, 0, customWord, 4'b0100);
    check(fcOk, "R10", "frameClk runs with one lane down", fcOk, 1);

    // R11: all lanes down
    pwrDown = '1;
    repeat (2 * W + 2) @(posedge clk);
    #1;
    begin
      bit quiet;
      quiet = 1;
      for (int i = 0; i < 2 * W; i++) begin
        if (frameClk || laneOut != '0) quiet = 0;
        #2;
        if (bitClk) quiet = 0;
        @(posedge clk); #1;
      end
      check(quiet, "R11", "clocks and lanes quiet", quiet, 1);
    end
    pwrDown = '0;
    waitFrame(); captureFrame(0, '0, 2'b00);
    checkLanes("R11", {NL*W{1'b1}}, 0, 0, customWord, '0);
    check(fcOk && bcOk, "R11", "clocks resume aligned", {fcOk, bcOk}, 2'b11);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule